// File: doc/BRIEF.md
# Up/Down Decimal Digit Counter with Preset

A synchronous single-digit decimal counter. It steps through the values 0 to 9, either upward or downward as chosen by a direction input. Counting upward it wraps from 9 to 0. Counting downward it wraps from 0 to 9. An active-low count enable freezes the digit when it is inactive. A synchronous preset input takes priority over counting and copies a 4-bit value into the digit.

Two status outputs support chaining digits into multi-decade counters. The terminal flag is a level that is high when the digit sits at the end of its range for the current direction. The ripple strobe is active low and pulses during the low half of the clock when the digit is at its terminal value and counting is enabled. The next decade can use that strobe as its enable. A preset value from 10 to 15 is accepted. An upward count brings it back to 0, and a downward count steps it down by one until it re-enters the range.

Top module: `bcd_updown_counter`

## Requirements
- R1: While rstN is low, count is 0; the first clock after release with the counter idle leaves it at 0.
- R2: With presetEn low, countEnN low and downSel low, a count from 0 to 8 becomes count+1 on the next rising clock edge.
- R3: With presetEn low, countEnN low and downSel low, a count of 9 becomes 0 on the next rising clock edge.
- R4: With presetEn low, countEnN low and downSel high, a count from 1 to 9 becomes count-1, and a count of 0 becomes 9, on the next rising clock edge.
- R5: With presetEn low and countEnN high, count does not change, whatever downSel is.
- R6: With presetEn high, count takes the value of presetVal on the next rising edge, whatever countEnN and downSel are.
- R7: termFlag is high exactly when downSel is low and count is 9, or when downSel is high and count is 0. It does not depend on countEnN.
- R8: rippleN is low only while clk is low, termFlag is high and countEnN is low. At all other times it is high.
- R9: Counting up from a preset value of 10 to 15 gives 0 on the next enabled clock.
- R10: Counting down from a preset value of 10 to 15 gives the value minus one on the next enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| downSel | input | 1 | Direction: 0 counts up, 1 counts down |
| countEnN | input | 1 | Count enable, active low |
| presetEn | input | 1 | Synchronous preset, active high, overrides counting |
| presetVal | input | 4 | Value copied into the counter on preset |
| count | output | 4 | Current digit |
| termFlag | output | 1 | Terminal value for the current direction reached |
| rippleN | output | 1 | Active-low cascade strobe in the clock low phase |

## Verification
The hardest states to reach are the out-of-range digits 10 to 15. Normal counting never produces them, so the stimulus uses the preset to place the counter there and then counts once in each direction. The ripple strobe is only valid in the low half of the clock. To check it, each step samples the outputs twice, once in each clock phase, while the inputs are held. The terminal flag is compared with the enable both active and inactive.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;
  // Strobes passed from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic loadStb;
    logic upStb;
    logic downStb;
  } ctrlStrobes_t;
endpackage

// File: rtl/bcdc_ctrl.sv
module bcdc_ctrl
  import bcdc_pkg::*;
(
  input  logic         downSel,
  input  logic         countEnN,
  input  logic         presetEn,
  output ctrlStrobes_t strobes,
  output logic         countActive
);
  always_comb begin
    countActive     = !countEnN;
    strobes.loadStb = presetEn;
    strobes.upStb   = !presetEn && countActive && !downSel;
    strobes.downStb = !presetEn && countActive && downSel;
  end
endmodule

// File: rtl/bcdc_datapath.sv
module bcdc_datapath
  import bcdc_pkg::*;
#(
  parameter int LAST_DIGIT = 9,
  parameter int CNT_W      = $clog2(LAST_DIGIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             downSel,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countQ,
  output logic             termFlag
);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST_DIGIT);
  localparam logic [CNT_W-1:0] ZERO_V = '0;
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic [CNT_W-1:0] nextCount;

  always_comb begin
    nextCount = countQ;
    if (strobes.loadStb) begin
      nextCount = loadVal;
    end else if (strobes.upStb) begin
      // values at or above the last digit fold back to zero
      nextCount = (countQ >= LAST_V) ? ZERO_V : countQ + ONE_V;
    end else if (strobes.downStb) begin
      nextCount = (countQ == ZERO_V) ? LAST_V : countQ - ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= ZERO_V;
    else       countQ <= nextCount;
  end

  always_comb termFlag = downSel ? (countQ == ZERO_V) : (countQ == LAST_V);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadStb, strobes.upStb, strobes.downStb}));  // R6
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.upStb && countQ == LAST_V |=> countQ == ZERO_V);  // R3
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.downStb && countQ == ZERO_V |=> countQ == LAST_V);  // R4
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.upStb && countQ < LAST_V |=> countQ == $past(countQ) + ONE_V);  // R2
  AST_UP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.upStb && countQ > LAST_V |=> countQ == ZERO_V);  // R9
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcdc_pkg::*;
#(
  parameter int LAST_DIGIT = 9,
  localparam int CNT_W     = $clog2(LAST_DIGIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             downSel,
  input  logic             countEnN,
  input  logic             presetEn,
  input  logic [CNT_W-1:0] presetVal,
  output logic [CNT_W-1:0] count,
  output logic             termFlag,
  output logic             rippleN
);
  ctrlStrobes_t strobes;
  logic         countActive;

  bcdc_ctrl i_ctrl (
    .downSel    (downSel),
    .countEnN   (countEnN),
    .presetEn   (presetEn),
    .strobes    (strobes),
    .countActive(countActive)
  );

  bcdc_datapath #(.LAST_DIGIT(LAST_DIGIT), .CNT_W(CNT_W)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .downSel (downSel),
    .loadVal (presetVal),
    .countQ  (count),
    .termFlag(termFlag)
  );

  // cascade strobe: open only in the low clock phase
  always_comb rippleN = !(termFlag && countActive && !clk);

  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !presetEn && countEnN |=> $stable(count));  // R5
  AST_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    presetEn |=> count == $past(presetVal));  // R6
  AST_RIPPLE_HIGH: assert property (@(negedge clk) disable iff (!rstN)
    rippleN);  // R8
  AST_RIPPLE_COND: assert property (@(posedge clk) disable iff (!rstN)
    !rippleN |-> termFlag && !countEnN);  // R8
endmodule

// File: tb/test_bcd_updown_counter.sv
`timescale 1ns/1ps
module test_bcd_updown_counter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       downSel = 1'b0;
  logic       countEnN = 1'b1;
  logic       presetEn = 1'b0;
  logic [3:0] presetVal = 4'd0;
  logic [3:0] count;
  logic       termFlag;
  logic       rippleN;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] expCount = 4'd0;

  always #2.5 clk = ~clk;

  bcd_updown_counter i_bcd_updown_counter (
    .clk(clk), .rstN(rstN), .downSel(downSel), .countEnN(countEnN),
    .presetEn(presetEn), .presetVal(presetVal),
    .count(count), .termFlag(termFlag), .rippleN(rippleN)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] model(logic [3:0] c, logic ld, logic enN,
                                       logic dn, logic [3:0] d);
    if (ld)        return d;                          // R6
    if (enN)       return c;                          // R5
    if (!dn)       return (c >= 4'd9) ? 4'd0 : c + 4'd1;  // R2 R3 R9
    return (c == 4'd0) ? 4'd9 : c - 4'd1;            // R4 R10
  endfunction

  // Apply inputs, clock once, check count and flags in both clock phases.
  task automatic tick(string req, logic ld, logic enN, logic dn, logic [3:0] d);
    logic expTerm;
    presetEn = ld; countEnN = enN; downSel = dn; presetVal = d;
    @(posedge clk); #1;
    expCount = model(expCount, ld, enN, dn, d);
    chk(req, count, expCount);
    expTerm = dn ? (expCount == 4'd0) : (expCount == 4'd9);
    chk("R7 termFlag", termFlag, expTerm);
    chk("R8 rippleN high phase", rippleN, 1);
    #2.5;
    chk("R8 rippleN low phase", rippleN, !(expTerm && !enN));
  endtask

  task automatic testReset();
    chk("R1 reset count", count, 0);
    #3.2 rstN = 1'b1;
    tick("R1 idle after reset", 1'b0, 1'b1, 1'b0, 4'd0);
  endtask

  task automatic testUpSweep();
    for (int i = 0; i < 12; i++) tick("R2/R3 up sweep", 1'b0, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic testDownSweep();
    tick("R6 preset 2", 1'b1, 1'b1, 1'b1, 4'd2);
    for (int i = 0; i < 12; i++) tick("R4 down sweep", 1'b0, 1'b0, 1'b1, 4'd0);
  endtask

  task automatic testHold();
    tick("R6 preset 5", 1'b1, 1'b0, 1'b0, 4'd5);
    tick("R5 hold up", 1'b0, 1'b1, 1'b0, 4'd7);
    tick("R5 hold down", 1'b0, 1'b1, 1'b1, 4'd7);
  endtask

  task automatic testPreset();
    tick("R6 preset with enable off", 1'b1, 1'b1, 1'b0, 4'd7);
    tick("R6 preset while counting down", 1'b1, 1'b0, 1'b1, 4'd3);
    tick("R6 preset while counting up", 1'b1, 1'b0, 1'b0, 4'd8);
  endtask

  task automatic testOutOfRange();
    for (int v = 10; v < 16; v++) begin
      tick("R6 preset out of range", 1'b1, 1'b1, 1'b0, 4'(v));
      tick("R9 up from out of range", 1'b0, 1'b0, 1'b0, 4'd0);
    end
    tick("R6 preset 13", 1'b1, 1'b1, 1'b1, 4'd13);
    tick("R10 down from 13", 1'b0, 1'b0, 1'b1, 4'd0);
    tick("R6 preset 10", 1'b1, 1'b1, 1'b1, 4'd10);
    tick("R10 down from 10", 1'b0, 1'b0, 1'b1, 4'd0);
  endtask

  task automatic testTerminal();
    tick("R6 preset 9", 1'b1, 1'b1, 1'b0, 4'd9);
    tick("R7 up at 9 enable off", 1'b0, 1'b1, 1'b0, 4'd0);
    tick("R7 down at 9 enable off", 1'b0, 1'b1, 1'b1, 4'd0);
    tick("R6 preset 0", 1'b1, 1'b1, 1'b1, 4'd0);
    tick("R7 down at 0 enable off", 1'b0, 1'b1, 1'b1, 4'd0);
    tick("R6 preset 1", 1'b1, 1'b1, 1'b1, 4'd1);
    tick("R8 down to 0 enabled", 1'b0, 1'b0, 1'b1, 4'd0);
  endtask

  initial begin
    testReset();
    testUpSweep();
    testDownSweep();
    testHold();
    testPreset();
    testOutOfRange();
    testTerminal();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule